// File: doc/BRIEF.md
# Prescaled Countdown Watchdog with Register Access

This block is a watchdog timer for a system-on-chip. A 16-bit down-counter is clocked through a power-of-two prescaler. Software programs a timeout by writing a load register. The same write, repeated while the timer runs, restarts the countdown and so serves as the periodic kick. A control word holds three fields: an enable bit, a mode field and a prescale code.

In watchdog mode, when the countdown runs out while the timer is enabled, the block raises a one-cycle registered reset request. It also sets a sticky expiry flag that software can read. Any other mode turns the block into a free-running periodic timer that reloads itself and never requests a reset. A load value of zero parks the counter, so that no expiry can happen. Software can read back the load register, the control register and the live count over a simple register bus with a combinational read port.

Top module: `wdog_timer`

## Requirements
- R1: After reset, reads at offsets 0x0, 0x4 and 0x8 return zero and the reset request is low.
- R2: A write to offset 0x0 stores bits 15:0 as the load value (readable at 0x0). At the same clock edge it sets the count, which is readable at 0x4, to that value.
- R3: Offset 0x8 is the control word: bit 7 is enable, bits 6:4 are the mode and bits 3:0 are the prescale code. These fields read back as written. Bit 15 reads as the expiry flag and ignores writes.
- R4: With enable set, prescale code 0 and a nonzero load, the count drops by one on every clock edge.
- R5: A prescale code n of 1 or more makes the count drop once every 2^(n+1) clocks. The division restarts from zero on each load write and on each rising edge of enable.
- R6: In mode 3, with enable set and load L with period P, the count expires L*P edges after the load write. The reset request is then high for exactly one cycle, and the count shows L again in that cycle.
- R7: Each watchdog expiry sets the expiry flag (control bit 15). The flag stays set until the next write to the load register.
- R8: A load write while the timer runs restarts the full countdown, so that kicks spaced more closely than the timeout never produce a reset request.
- R9: With a load value of zero, the count stays at zero and no reset request is ever raised, even when the timer is enabled in mode 3.
- R10: Clearing enable freezes the count at its current value. Setting enable again resumes the countdown from that value.
- R11: In any mode other than 3, the count reloads from the load value when it runs out. The reset request and the expiry flag stay low.
- R12: Writes to offsets other than 0x0 and 0x8 change nothing. Reads of offsets other than 0x0, 0x4 and 0x8 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rst_req | output | 1 | Registered one-cycle system reset request |

## Verification
The hardest case to reach from the ports is the edge at which the prescaler, the count and the reset request all line up. There the bench must sample exactly L*P edges after a load write. Being one edge off would either miss the pulse or see it in the wrong cycle. Each scenario first parks the timer with a zero load, then programs the control word, and only then writes the real load value. This makes the load write the single reference edge from which the bench counts. Reset request, count and flag are then checked cycle by cycle for small prescale codes, where the period is short enough to sweep completely.

// File: rtl/wdog_pkg.sv
// Package: wdog_pkg
// Shared widths, register offsets and control-field positions for the
// watchdog. Assumes a byte-addressed bus with word-aligned registers.
package wdog_pkg;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int MODE_W = 3;
    localparam int PSC_W  = 4;

    localparam logic [ADDR_W-1:0] OFS_LOAD  = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'h8;

    localparam int EN_BIT   = 7;
    localparam int MODE_LSB = 4;
    localparam int PSC_LSB  = 0;
    localparam int EXP_BIT  = 15;

    localparam logic [MODE_W-1:0] MODE_WDOG = 3'd3;
endpackage

// File: rtl/wdog_prescaler.sv
// Module: wdog_prescaler
// Generates a tick every 2^(psc+1) running cycles, or every running
// cycle when psc is zero. Assumes clear is asserted for one cycle on a
// load write or an enable rise; the free count restarts from zero.
module wdog_prescaler #(
    parameter int PSC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    localparam int PRE_W = 1 << PSC_W;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    // Build the low-bit mask: bits 0..psc set for psc >= 1, empty for psc 0.
    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
        assign mask[i] = (psc != '0) && (i <= int'(psc));
    end

    // Free-running division counter, restarted by clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      pre_q <= '0;
        else if (clear)  pre_q <= '0;
        else if (run)    pre_q <= pre_q + 1'b1;
    end

    // Tick when all masked low bits are ones.
    assign tick = run && ((pre_q & mask) == mask);
endmodule

// File: rtl/wdog_counter.sv
// Module: wdog_counter
// The countdown register. A load write sets it, a tick decrements it, and
// at one it reloads and signals terminal. Assumes run is low while the
// reload value is zero.
module wdog_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_data,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             run,
    input  logic             tick,
    input  logic             wdog_mode,
    output logic [CNT_W-1:0] count,
    output logic             terminal,
    output logic             rst_req
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // The countdown ends on a tick while the count is one; a load write wins.
    assign terminal = run && tick && !load_wr && (count <= ONE);

    // Count register: load, reload on terminal, or decrement on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                count <= '0;
        else if (load_wr)          count <= load_data;
        else if (terminal)         count <= reload_val;
        else if (run && tick)      count <= count - 1'b1;
    end

    // Registered reset request, only in watchdog mode.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= terminal && wdog_mode;
    end
endmodule

// File: rtl/wdog_regs.sv
// Module: wdog_regs
// Register decode: the load and control registers, the sticky expiry flag
// and the read mux. Assumes at most one bus write per cycle; unmapped
// offsets are ignored on write and read as zero.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int A_W = ADDR_W,
    parameter int D_W = DATA_W,
    parameter int C_W = CNT_W,
    parameter int M_W = MODE_W,
    parameter int P_W = PSC_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [A_W-1:0] bus_addr,
    input  logic           bus_we,
    input  logic [D_W-1:0] bus_wdata,
    output logic [D_W-1:0] bus_rdata,
    input  logic [C_W-1:0] cnt_val,
    input  logic           expire_set,
    output logic [C_W-1:0] load_q,
    output logic           ctrl_en,
    output logic [M_W-1:0] ctrl_mode,
    output logic [P_W-1:0] ctrl_psc,
    output logic           load_wr,
    output logic           en_rise,
    output logic           expired
);
    logic ctrl_wr;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[D_W-1:C_W];

    // Write strobes per register.
    assign load_wr = bus_we && (bus_addr == OFS_LOAD);
    assign ctrl_wr = bus_we && (bus_addr == OFS_CTRL);
    assign en_rise = ctrl_wr && bus_wdata[EN_BIT] && !ctrl_en;

    // Load register.
    always_ff @(posedge clk) begin
        if (!rst_n)       load_q <= '0;
        else if (load_wr) load_q <= bus_wdata[C_W-1:0];
    end

    // Control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en   <= 1'b0;
            ctrl_mode <= '0;
            ctrl_psc  <= '0;
        end else if (ctrl_wr) begin
            ctrl_en   <= bus_wdata[EN_BIT];
            ctrl_mode <= bus_wdata[MODE_LSB +: M_W];
            ctrl_psc  <= bus_wdata[PSC_LSB +: P_W];
        end
    end

    // Sticky expiry flag: a load write clears it, a watchdog expiry sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)          expired <= 1'b0;
        else if (load_wr)    expired <= 1'b0;
        else if (expire_set) expired <= 1'b1;
    end

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_LOAD:  bus_rdata[C_W-1:0] = load_q;
            OFS_COUNT: bus_rdata[C_W-1:0] = cnt_val;
            OFS_CTRL: begin
                bus_rdata[EXP_BIT]            = expired;
                bus_rdata[EN_BIT]             = ctrl_en;
                bus_rdata[MODE_LSB +: M_W]    = ctrl_mode;
                bus_rdata[PSC_LSB +: P_W]     = ctrl_psc;
            end
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_timer.sv
// Module: wdog_timer (top)
// A register-mapped watchdog: a prescaled 16-bit countdown that requests
// a system reset on expiry in mode 3 and free-runs in other modes.
// Assumes a synchronous active-low reset; all state resets to zero.
module wdog_timer
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req
);
    logic [CNT_W-1:0]  load_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              ctrl_en;
    logic [MODE_W-1:0] ctrl_mode;
    logic [PSC_W-1:0]  ctrl_psc;
    logic              load_wr;
    logic              en_rise;
    logic              expired_q;
    logic              run;
    logic              tick;
    logic              terminal;
    logic              wdog_mode;
    logic              expire_set;

    // Run only when enabled with a nonzero load; zero load parks the timer.
    assign run        = ctrl_en && (load_q != '0);
    assign wdog_mode  = (ctrl_mode == MODE_WDOG);
    assign expire_set = terminal && wdog_mode;

    wdog_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cnt_val    (cnt_q),
        .expire_set (expire_set),
        .load_q     (load_q),
        .ctrl_en    (ctrl_en),
        .ctrl_mode  (ctrl_mode),
        .ctrl_psc   (ctrl_psc),
        .load_wr    (load_wr),
        .en_rise    (en_rise),
        .expired    (expired_q)
    );

    wdog_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clear (load_wr || en_rise),
        .psc   (ctrl_psc),
        .tick  (tick)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_wr    (load_wr),
        .load_data  (bus_wdata[CNT_W-1:0]),
        .reload_val (load_q),
        .run        (run),
        .tick       (tick),
        .wdog_mode  (wdog_mode),
        .count      (cnt_q),
        .terminal   (terminal),
        .rst_req    (rst_req)
    );
endmodule

// File: rtl/wdog_checker.sv
// Module: wdog_checker
// Temporal properties of the watchdog, bound to wdog_timer. Assumes it
// observes the top-level bus and the internal register outputs.
module wdog_checker
    import wdog_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [CNT_W-1:0]  wdata,
    input logic              rst_req,
    input logic              en,
    input logic [MODE_W-1:0] mode,
    input logic [CNT_W-1:0]  load_q,
    input logic [CNT_W-1:0]  count,
    input logic              expired
);
    AST_LOAD_SETS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_LOAD) |=> (count == $past(wdata))); // R2

    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !(bus_we && bus_addr == OFS_LOAD)) |=> $stable(count)); // R10

    AST_ZERO_LOAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (load_q == '0) |=> !rst_req); // R9

    AST_RST_NEEDS_WDOG: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(en && mode == MODE_WDOG)); // R6

    AST_RST_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> expired); // R7

    AST_FREE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(mode == MODE_WDOG)); // R11
endmodule

bind wdog_timer wdog_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_addr(bus_addr),
    .bus_we  (bus_we),
    .wdata   (bus_wdata[15:0]),
    .rst_req (rst_req),
    .en      (ctrl_en),
    .mode    (ctrl_mode),
    .load_q  (load_q),
    .count   (cnt_q),
    .expired (expired_q)
);

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    wdog_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Drive one write; applied at the next rising edge, returns just after it.
    task automatic bus_write(logic [3:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    // Advance k rising edges, then stop at the following falling edge.
    task automatic step(int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    // Park the timer: zero load, then program control.
    task automatic setup(logic [31:0] ctrl);
        bus_write(4'h0, 32'h0);
        bus_write(4'h8, ctrl);
        step(0);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(4'h0, v); chk("R1 load", v, 0);
        rd(4'h4, v); chk("R1 count", v, 0);
        rd(4'h8, v); chk("R1 ctrl", v, 0);
        chk("R1 rst_req", rst_req, 0);
    endtask

    task automatic t_ctrl_fields;
        logic [31:0] v;
        setup(32'h0000_80B5);
        rd(4'h8, v); chk("R3 ctrl readback, bit15 read-only", v, 32'h0000_00B5);
        bus_write(4'h8, 32'h0); step(0);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        setup(32'h0);
        bus_write(4'h0, 32'hABCD_1234); step(0);
        rd(4'h0, v); chk("R2 load readback", v, 32'h1234);
        rd(4'h4, v); chk("R2 count loaded", v, 32'h1234);
        bus_write(4'h4, 32'hFFFF); bus_write(4'hC, 32'hFFFF);
        bus_write(4'h1, 32'h00FF); step(0);
        rd(4'h0, v); chk("R12 load unchanged", v, 32'h1234);
        rd(4'h4, v); chk("R12 count unchanged", v, 32'h1234);
        rd(4'h8, v); chk("R12 ctrl unchanged", v, 0);
        rd(4'hC, v); chk("R12 unmapped read", v, 0);
    endtask

    task automatic t_wdog_expire;
        logic [31:0] v;
        setup(32'h0000_00B0);                  // en, mode 3, code 0
        bus_write(4'h0, 32'd5);
        for (int k = 1; k <= 7; k++) begin
            step(1);
            chk($sformatf("R6 rst_req at %0d", k), rst_req, (k == 5));
            if (k == 2) begin rd(4'h4, v); chk("R4 count per clock", v, 3); end
            if (k == 5) begin
                rd(4'h4, v); chk("R6 reload on expiry", v, 5);
                rd(4'h8, v); chk("R7 flag set", v[15], 1);
            end
        end
        rd(4'h8, v); chk("R7 flag sticky", v[15], 1);
        bus_write(4'h0, 32'd0); step(0);
        rd(4'h8, v); chk("R7 flag cleared by load", v[15], 0);
    endtask

    task automatic t_prescale;
        logic [31:0] v;
        setup(32'h0000_00B1);                  // code 1: divide by 4
        bus_write(4'h0, 32'd3);
        for (int k = 1; k <= 13; k++) begin
            step(1);
            if (k == 3) begin rd(4'h4, v); chk("R5 /4 hold", v, 3); end
            if (k == 4) begin rd(4'h4, v); chk("R5 /4 step", v, 2); end
            chk($sformatf("R5 /4 rst_req at %0d", k), rst_req, (k == 12));
        end
        setup(32'h0000_00B2);                  // code 2: divide by 8
        bus_write(4'h0, 32'd2);
        for (int k = 1; k <= 17; k++) begin
            step(1);
            if (k == 7) begin rd(4'h4, v); chk("R5 /8 hold", v, 2); end
            if (k == 8) begin rd(4'h4, v); chk("R5 /8 step", v, 1); end
            chk($sformatf("R5 /8 rst_req at %0d", k), rst_req, (k == 16));
        end
    endtask

    task automatic t_kick;
        int seen = 0;
        setup(32'h0000_00B0);
        bus_write(4'h0, 32'd6);
        for (int r = 0; r < 4; r++) begin
            step(4);
            if (rst_req) seen++;
            bus_write(4'h0, 32'd6);
        end
        for (int k = 1; k <= 6; k++) begin
            step(1);
            if (k < 6 && rst_req) seen++;
            if (k == 6) chk("R8 expiry after last kick", rst_req, 1);
        end
        chk("R8 no reset while kicked", seen, 0);
    endtask

    task automatic t_zero_load;
        logic [31:0] v;
        int seen = 0;
        setup(32'h0000_00B0);
        for (int k = 1; k <= 20; k++) begin
            step(1);
            if (rst_req) seen++;
        end
        rd(4'h4, v); chk("R9 count stays zero", v, 0);
        chk("R9 no reset with zero load", seen, 0);
    endtask

    task automatic t_disable;
        logic [31:0] v;
        setup(32'h0000_0030);                  // mode 3, disabled
        bus_write(4'h0, 32'd10);
        bus_write(4'h8, 32'h0000_00B0);        // enable: count starts at this edge+1
        step(3);
        rd(4'h4, v); chk("R10 running", v, 7);
        bus_write(4'h8, 32'h0000_0030);        // this edge still counts
        step(0);
        rd(4'h4, v); chk("R10 last step", v, 6);
        step(5);
        rd(4'h4, v); chk("R10 frozen", v, 6);
        bus_write(4'h8, 32'h0000_00B0);
        step(1);
        rd(4'h4, v); chk("R10 resumed", v, 5);
    endtask

    task automatic t_free_run;
        logic [31:0] v;
        int seen = 0;
        setup(32'h0000_0080);                  // en, mode 0, code 0
        bus_write(4'h0, 32'd3);
        for (int k = 1; k <= 9; k++) begin
            step(1);
            if (rst_req) seen++;
            if (k == 3) begin rd(4'h4, v); chk("R11 reload", v, 3); end
            if (k == 4) begin rd(4'h4, v); chk("R11 continue", v, 2); end
        end
        chk("R11 no reset request", seen, 0);
        rd(4'h8, v); chk("R11 no flag", v[15], 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step(0);
        t_reset();
        t_ctrl_fields();
        t_unmapped();
        t_wdog_expire();
        t_prescale();
        t_kick();
        t_zero_load();
        t_disable();
        t_free_run();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule